// File: doc/BRIEF.md
# DRAM Power-Down Entry/Exit Sequencer

This block sits on the controller side of a DDR2-style memory interface. It moves the device into power-down and back out again. When the scheduler signals that the interface is idle, the sequencer checks that no data burst and no write recovery is still running. It then drops the clock-enable line while the command bus carries a no-operation code. It records which flavour of power-down it has entered: precharge, fast-exit active or slow-exit active. It holds that state, with the chip-select line released, until a wake request arrives or until the residency ceiling is reached.

On exit, the sequencer raises clock-enable together with a no-operation code. It then counts the exit latency that belongs to the recorded flavour. Only when that count reaches zero does it raise `cmd_ready` to tell the scheduler that a new command may be issued. The residency ceiling is a multiple of the refresh interval. All timing values are clock-cycle counts given by parameters.

The state machine has four states:
- `ST_IDLE`: normal operation. Clock-enable is high, the bus carries NOP and `cmd_ready` is high.
- `ST_ENTER`: the first clock-enable-low cycle. The bus carries NOP.
- `ST_PD`: power-down proper. The bus carries Deselect.
- `ST_EXIT`: clock-enable is high again, the bus carries NOP and the latency count is running.

Its transitions are:
- IDLE→ENTER, on an allowed entry request.
- ENTER→PD, always.
- PD→EXIT, on a wake request, a held wake, or the residency limit.
- EXIT→IDLE, when the latency counter is zero.

Top module: `dram_pd_sequencer`

## Requirements
- R1: In `ST_IDLE`, a cycle with `idle_req` high and both `burst_busy` and `wr_recov_busy` low is followed by a cycle in which `cke` is 0 and the bus carries NOP. NOP means `cs_n`=0 and `ras_n`=`cas_n`=`we_n`=1. `cmd_ready` is 0 in that cycle.
- R2: While `burst_busy` or `wr_recov_busy` is high, no entry happens: `cke` and `cmd_ready` stay 1 whatever `idle_req` does.
- R3: The flavour is decided from `bank_open` and `lp_exit` in the request cycle. `pd_mode` shows it from the first `cke`-low cycle on. The codes are 0 for precharge (all `bank_open` bits 0), 1 for fast-exit active (some bit set and `lp_exit`=0) and 2 for slow-exit active (some bit set and `lp_exit`=1). After reset `pd_mode` is 0.
- R4: Every `cke`-low cycle after the first carries Deselect: `cs_n`=`ras_n`=`cas_n`=`we_n`=1.
- R5: `wake_req` high during a Deselect cycle is followed by a cycle with `cke`=1, NOP on the bus and `cmd_ready`=0.
- R6: `cmd_ready` stays 0 for exactly T_XP (precharge), T_XARD (fast) or T_XARDS (slow) cycles, counted from the first `cke`-high cycle. It is 1 in the cycle after that.
- R7: A `wake_req` during the first `cke`-low cycle is held. `cke` then stays low for exactly two cycles in total.
- R8: `cke` never stays low for more than REFI_MULT×T_REFI consecutive cycles. With no wake, it stays low for exactly that many.
- R9: `wake_req` while in `ST_IDLE` has no effect: `cke` and `cmd_ready` stay 1.
- R10: After reset, `cke`=1, the bus carries NOP and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Scheduler asks for power-down |
| bank_open | input | NBANK | One bit per bank, set while a row is open |
| burst_busy | input | 1 | A read or write burst is in progress |
| wr_recov_busy | input | 1 | Write recovery is still running |
| lp_exit | input | 1 | Mode-register bit choosing slow low-power exit for active power-down |
| wake_req | input | 1 | Request to leave power-down |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cmd_ready | output | 1 | A new command may be issued |
| pd_mode | output | 2 | Flavour of the most recent entry (0/1/2) |

## Verification
The bench sweeps every open-bank pattern of a four-bank build against both exit-mode settings. For each combination it measures the entry flavour and the length of the not-ready window. A design that swapped the fast and slow latencies, or tested only bank 0, would show the wrong code or a window one to four cycles off. Wake is driven on the entry cycle, to catch a design that drops the wake and sleeps until the ceiling. Holds are driven just below, at, and beyond the residency limit, to expose an off-by-one in the ceiling. Busy flags and an idle-state wake are driven too, to catch entry during a burst or a spurious clock-enable toggle.

// File: rtl/dram_pd_pkg.sv
package dram_pd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTER = 2'd1,
        ST_PD    = 2'd2,
        ST_EXIT  = 2'd3
    } pd_state_t;

    typedef enum logic [1:0] {
        PDM_PRECHARGE = 2'd0,
        PDM_ACT_FAST  = 2'd1,
        PDM_ACT_SLOW  = 2'd2
    } pd_mode_t;

endpackage

// File: rtl/dram_pd_mode_sel.sv
module dram_pd_mode_sel
    import dram_pd_pkg::*;
#(
    parameter int NBANK   = 8,
    parameter int T_XP    = 2,
    parameter int T_XARD  = 2,
    parameter int T_XARDS = 8,
    parameter int LAT_W   = 4
) (
    input  logic [NBANK-1:0] bank_open,
    input  logic             lp_exit,
    input  pd_mode_t         cur_mode,
    output pd_mode_t         new_mode,
    output logic [LAT_W-1:0] latency
);

    // Flavour chosen from the bank status at the request cycle.
    always_comb begin
        if (|bank_open) begin
            new_mode = lp_exit ? PDM_ACT_SLOW : PDM_ACT_FAST;
        end else begin
            new_mode = PDM_PRECHARGE;
        end
    end

    // Exit latency belonging to the flavour that was entered.
    always_comb begin
        unique case (cur_mode)
            PDM_PRECHARGE: latency = LAT_W'(T_XP);
            PDM_ACT_FAST:  latency = LAT_W'(T_XARD);
            PDM_ACT_SLOW:  latency = LAT_W'(T_XARDS);
            default:       latency = LAT_W'(T_XP);
        endcase
    end

endmodule

// File: rtl/dram_pd_lat_timer.sv
module dram_pd_lat_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [LAT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && (count != '0)) begin
            count <= count - LAT_W'(1);
        end
    end

    assign zero = (count == '0);

endmodule

// File: rtl/dram_pd_res_timer.sv
module dram_pd_res_timer #(
    parameter int MAX_RES = 14040,
    parameter int RES_W   = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    logic [RES_W-1:0] count;

    // count = number of low cycles completed before the current one
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + RES_W'(1);
        end
    end

    assign at_limit = (count == RES_W'(MAX_RES - 1));

endmodule

// File: rtl/dram_pd_sequencer.sv
module dram_pd_sequencer
    import dram_pd_pkg::*;
#(
    parameter int NBANK     = 8,
    parameter int T_XP      = 2,
    parameter int T_XARD    = 2,
    parameter int T_XARDS   = 8,
    parameter int T_REFI    = 1560,
    parameter int REFI_MULT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic [NBANK-1:0] bank_open,
    input  logic             burst_busy,
    input  logic             wr_recov_busy,
    input  logic             lp_exit,
    input  logic             wake_req,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             cmd_ready,
    output logic [1:0]       pd_mode
);

    localparam int MAX_RES  = T_REFI * REFI_MULT;
    localparam int RES_W    = $clog2(MAX_RES + 1);
    localparam int LAT_MAX0 = (T_XP > T_XARD) ? T_XP : T_XARD;
    localparam int LAT_MAX  = (LAT_MAX0 > T_XARDS) ? LAT_MAX0 : T_XARDS;
    localparam int LAT_W    = $clog2(LAT_MAX + 1);

    pd_state_t        state, state_nx;
    pd_mode_t         mode_q, mode_new;
    logic             wake_pend;
    logic             can_enter;
    logic             go_exit;
    logic             res_limit;
    logic             lat_zero;
    logic [LAT_W-1:0] latency;

    assign can_enter = idle_req && !burst_busy && !wr_recov_busy;
    assign go_exit   = (state == ST_PD) && (wake_req || wake_pend || res_limit);

    dram_pd_mode_sel #(
        .NBANK  (NBANK),
        .T_XP   (T_XP),
        .T_XARD (T_XARD),
        .T_XARDS(T_XARDS),
        .LAT_W  (LAT_W)
    ) u_mode_sel (
        .bank_open(bank_open),
        .lp_exit  (lp_exit),
        .cur_mode (mode_q),
        .new_mode (mode_new),
        .latency  (latency)
    );

    dram_pd_lat_timer #(
        .LAT_W(LAT_W)
    ) u_lat_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go_exit),
        .load_val(latency - LAT_W'(1)),
        .dec     (state == ST_EXIT),
        .zero    (lat_zero)
    );

    dram_pd_res_timer #(
        .MAX_RES(MAX_RES),
        .RES_W  (RES_W)
    ) u_res_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE),
        .inc     ((state == ST_ENTER) || (state == ST_PD)),
        .at_limit(res_limit)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (can_enter) state_nx = ST_ENTER;
            ST_ENTER: state_nx = ST_PD;
            ST_PD:    if (go_exit) state_nx = ST_EXIT;
            ST_EXIT:  if (lat_zero) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register plus entry bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= PDM_PRECHARGE;
            wake_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if ((state == ST_IDLE) && can_enter) begin
                mode_q <= mode_new;
            end
            if ((state == ST_ENTER) && wake_req) begin
                wake_pend <= 1'b1;
            end else if (go_exit) begin
                wake_pend <= 1'b0;
            end
        end
    end

    // Output decode
    always_comb begin
        cke       = 1'b1;
        cs_n      = 1'b0;
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        we_n      = 1'b1;
        cmd_ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
            end
            ST_ENTER: begin
                cke = 1'b0;
            end
            ST_PD: begin
                cke  = 1'b0;
                cs_n = 1'b1;
            end
            ST_EXIT: begin
                cke = 1'b1;
            end
            default: begin
                cke = 1'b1;
            end
        endcase
    end

    assign pd_mode = mode_q;

endmodule

// File: rtl/dram_pd_sequencer_chk.sv
module dram_pd_sequencer_chk #(
    parameter int NBANK     = 8,
    parameter int T_XP      = 2,
    parameter int T_XARD    = 2,
    parameter int T_XARDS   = 8,
    parameter int T_REFI    = 1560,
    parameter int REFI_MULT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_req,
    input logic [NBANK-1:0] bank_open,
    input logic             burst_busy,
    input logic             wr_recov_busy,
    input logic             lp_exit,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             cmd_ready,
    input logic [1:0]       pd_mode
);

    localparam int MAX_RES = T_REFI * REFI_MULT;
    localparam int RES_W   = $clog2(MAX_RES + 1);

    logic [RES_W-1:0] low_cnt;
    logic [15:0]      hi_cnt;
    int               exp_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            if (!cke) begin
                if (low_cnt != RES_W'(MAX_RES)) low_cnt <= low_cnt + RES_W'(1);
                hi_cnt <= '0;
            end else begin
                low_cnt <= '0;
                if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
            end
        end
    end

    always_comb begin
        if (pd_mode == 2'd1)      exp_lat = T_XARD;
        else if (pd_mode == 2'd2) exp_lat = T_XARDS;
        else                      exp_lat = T_XP;
    end

    assert_entry_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!cs_n && ras_n && cas_n && we_n && !cmd_ready));

    assert_entry_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(idle_req && !burst_busy && !wr_recov_busy));

    assert_mode_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (pd_mode == (!$past(|bank_open) ? 2'd0 : ($past(lp_exit) ? 2'd2 : 2'd1))));

    assert_pd_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (cs_n && ras_n && cas_n && we_n));

    assert_exit_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!cs_n && ras_n && cas_n && we_n && !cmd_ready));

    assert_ready_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> cke);

    assert_exit_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> (int'(hi_cnt) == exp_lat));

    assert_residency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (int'(low_cnt) < MAX_RES));

endmodule

bind dram_pd_sequencer dram_pd_sequencer_chk #(
    .NBANK    (NBANK),
    .T_XP     (T_XP),
    .T_XARD   (T_XARD),
    .T_XARDS  (T_XARDS),
    .T_REFI   (T_REFI),
    .REFI_MULT(REFI_MULT)
) u_chk (.*);

// File: tb/dram_pd_sequencer_test.sv
module dram_pd_sequencer_test;

    localparam int NBANK     = 4;
    localparam int T_XP      = 2;
    localparam int T_XARD    = 3;
    localparam int T_XARDS   = 6;
    localparam int T_REFI    = 4;
    localparam int REFI_MULT = 9;
    localparam int MAX_RES   = T_REFI * REFI_MULT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             idle_req = 1'b0;
    logic [NBANK-1:0] bank_open = '0;
    logic             burst_busy = 1'b0;
    logic             wr_recov_busy = 1'b0;
    logic             lp_exit = 1'b0;
    logic             wake_req = 1'b0;
    logic             cke, cs_n, ras_n, cas_n, we_n, cmd_ready;
    logic [1:0]       pd_mode;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dram_pd_sequencer #(
        .NBANK(NBANK), .T_XP(T_XP), .T_XARD(T_XARD), .T_XARDS(T_XARDS),
        .T_REFI(T_REFI), .REFI_MULT(REFI_MULT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .bank_open(bank_open),
        .burst_busy(burst_busy), .wr_recov_busy(wr_recov_busy), .lp_exit(lp_exit),
        .wake_req(wake_req), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cmd_ready(cmd_ready), .pd_mode(pd_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit is_nop();
        return !cs_n && ras_n && cas_n && we_n;
    endfunction

    function automatic bit is_desel();
        return cs_n && ras_n && cas_n && we_n;
    endfunction

    // One full entry/exit sequence; hold = Deselect cycle on which wake is raised
    task automatic run_pd(input logic [NBANK-1:0] banks, input logic lp,
                          input int hold, input bit early_wake);
        int exp_mode, exp_lat, exp_low, low, pdc, n;
        exp_mode = (banks == '0) ? 0 : (lp ? 2 : 1);
        exp_lat  = (exp_mode == 0) ? T_XP : ((exp_mode == 1) ? T_XARD : T_XARDS);
        if (early_wake)            exp_low = 2;
        else if (1 + hold > MAX_RES) exp_low = MAX_RES;
        else                       exp_low = 1 + hold;

        @(negedge clk);
        bank_open = banks; lp_exit = lp; idle_req = 1'b1;
        @(negedge clk);
        chk(!cke && is_nop() && !cmd_ready, "R1 entry cycle", {cke, cs_n, cmd_ready}, 3'b000);
        chk(int'(pd_mode) == exp_mode, "R3 mode code", int'(pd_mode), exp_mode);
        idle_req = 1'b0; bank_open = '0; lp_exit = 1'b0;
        wake_req = early_wake;
        low = 1; pdc = 0;
        forever begin
            @(negedge clk);
            if (cke) break;
            low++; pdc++;
            if (!is_desel()) chk(1'b0, "R4 deselect in power-down", int'(cs_n), 1);
            wake_req = (!early_wake && pdc == hold);
        end
        wake_req = 1'b0;
        chk(is_nop() && !cmd_ready, "R5 exit cycle NOP", {cs_n, cmd_ready}, 0);
        if (early_wake) chk(low == exp_low, "R7 held wake", low, exp_low);
        else            chk(low == exp_low, "R8 low duration", low, exp_low);
        n = 0;
        while (!cmd_ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_lat, "R6 exit latency", n, exp_lat);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cke && is_nop() && cmd_ready, "R10 reset outputs", {cke, cs_n, cmd_ready}, 3'b101);
        chk(pd_mode == 2'd0, "R3 reset mode", int'(pd_mode), 0);

        // R2 busy flags block entry
        burst_busy = 1'b1; idle_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(cke && cmd_ready, "R2 burst blocks entry", {cke, cmd_ready}, 3);
        end
        burst_busy = 1'b0; wr_recov_busy = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(cke && cmd_ready, "R2 recovery blocks entry", {cke, cmd_ready}, 3);
        end
        idle_req = 1'b0; wr_recov_busy = 1'b0;

        // R9 wake in idle ignored
        wake_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cke && cmd_ready && is_nop(), "R9 idle wake ignored", {cke, cmd_ready}, 3);
        end
        wake_req = 1'b0;

        // Sweep: all bank patterns x exit-mode bit x two holds
        for (int b = 0; b < (1 << NBANK); b++) begin
            for (int l = 0; l < 2; l++) begin
                run_pd(NBANK'(b), l[0], 1, 1'b0);
                run_pd(NBANK'(b), l[0], 4, 1'b0);
            end
        end

        // R7 wake during entry cycle
        for (int l = 0; l < 2; l++) begin
            run_pd('0, l[0], 1, 1'b1);
            run_pd(4'b0100, l[0], 1, 1'b1);
        end

        // R8 residency ceiling corners
        run_pd(4'b0001, 1'b0, MAX_RES - 2, 1'b0);
        run_pd(4'b0001, 1'b1, MAX_RES - 1, 1'b0);
        run_pd('0, 1'b0, MAX_RES, 1'b0);
        run_pd('0, 1'b0, MAX_RES + 50, 1'b0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule